// File: doc/BRIEF.md
# Dual-Mode Charge-Current Setpoint Decoder

This block watches the single pin that sets the charge current. Once the charger signals that it is ready, the block decides whether the pin carries a pulse-width clock or a static analog level. A pin that toggles soon after ready selects PWM mode. A pin that stays quiet for the whole detection window selects analog mode, and the digital measurement path then stays off until the next ready pulse.

In PWM mode the block passes the pin through a two-flop synchroniser. It counts the high time and the period in sampling-clock cycles, one period running from one rising edge to the next. It turns the ratio into an 8-bit current-setpoint code and pulses a valid strobe once for each completed period. A pin stuck low for longer than the longest allowed period is read as zero duty, and the block raises a shutdown request. A pin stuck high is read as full scale.

Both lengths are parameters given in sampling-clock cycles. `DETECT_WIN` is the detection window, nominally 20 ms. `MAX_PERIOD` is the longest period, set by the 128 Hz lower frequency limit. The shortest usable period is a few cycles, so a 500 kHz input needs a sampling clock of at least a few MHz.

Top module: `duty_setpoint_decoder`

## Requirements
- R1: After reset, `pwm_mode`, `analog_mode`, `sp_valid` and `shdn_req` are 0 and `sp_code` is 0.
- R2: An edge of either polarity on the synchronised pin within `DETECT_WIN` cycles after a `chg_ready` pulse sets `pwm_mode` to 1.
- R3: If no edge arrives within `DETECT_WIN` cycles after `chg_ready`, `analog_mode` becomes 1. While in analog mode, pin toggles produce no `sp_valid` and `sp_code` stays 0.
- R4: `pwm_mode` and `analog_mode` are never both 1. A decision holds until the next `chg_ready`. A `chg_ready` pulse restarts detection and clears both mode flags, `sp_code` and `shdn_req` on the following cycle.
- R5: For each completed period (P cycles between rising edges, H of them high), `sp_code` = min(255, floor(256*H/P + 0.5)), together with a one-cycle `sp_valid`. The first rising edge after entering PWM mode, or after a stall, only starts a period and produces no result.
- R6: A duty of 99.5% or more (for example H=199, P=200) gives `sp_code` = 255.
- R7: In PWM mode, a pin held low with no rising edge for `MAX_PERIOD` cycles gives one `sp_valid` with `sp_code` = 0 and sets `shdn_req` to 1. The next completed period clears `shdn_req`.
- R8: In PWM mode, a pin held high with no rising edge for `MAX_PERIOD` cycles gives one `sp_valid` with `sp_code` = 255 and `shdn_req` = 0.
- R9: Periods from a few cycles up to exactly `MAX_PERIOD` cycles are measured without a timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chg_ready | input | 1 | One-cycle pulse: charger ready, start mode detection |
| pin_in | input | 1 | Raw setpoint pin level |
| pwm_mode | output | 1 | Pin decided to carry a PWM clock |
| analog_mode | output | 1 | Pin decided to carry a static level |
| sp_code | output | 8 | Current-setpoint code from measured duty |
| sp_valid | output | 1 | One-cycle strobe when `sp_code` is updated |
| shdn_req | output | 1 | Shutdown request on zero duty |

## Verification
Assertions check several rules on every cycle:
- the two mode flags are exclusive, and a decision holds until `chg_ready`;
- an edge seen while detecting moves the block into PWM mode, and the window counter never passes its limit;
- a strobe only follows a cycle in PWM mode;
- the high count never exceeds the period count;
- `shdn_req` always comes with a zero code, and a high-level timeout yields full scale.

The duty arithmetic itself is left to the bench scenarios: the rounding, the 99.5% boundary, the shortest and longest periods, and the rule that the first rising edge yields no result. So are the one-strobe-per-stall behaviour and the silence of the measurement path in analog mode. The bench compares each strobe with a queue of values it computes itself.

// File: rtl/setpt_pkg.sv
package setpt_pkg;

  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,
    MS_WAIT   = 2'd1,
    MS_PWM    = 2'd2,
    MS_ANALOG = 2'd3
  } mode_state_e;

  localparam int unsigned CODE_W   = 8;
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

  // Rounded duty code: floor((2*256*hi + per) / (2*per)), saturated.
  function automatic logic [CODE_W-1:0] duty_to_code(input logic [31:0] hi,
                                                     input logic [31:0] per);
    logic [63:0] num;
    logic [63:0] den;
    logic [63:0] quo;
    if (per == 32'd0) return CODE_W'(CODE_MAX);
    num = (64'(hi) << (CODE_W + 1)) + 64'(per);
    den = 64'(per) << 1;
    quo = num / den;
    if (quo > 64'(CODE_MAX)) return CODE_W'(CODE_MAX);
    return quo[CODE_W-1:0];
  endfunction

endpackage

// File: rtl/setpt_sync_edge.sv
module setpt_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic level,
  output logic rise,
  output logic fall
);
  logic s_meta, s_q, s_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_q    <= 1'b0;
      s_d    <= 1'b0;
    end else begin
      s_meta <= pin_raw;
      s_q    <= s_meta;
      s_d    <= s_q;
    end
  end

  assign level = s_q;
  assign rise  = s_q & ~s_d;
  assign fall  = ~s_q & s_d;
endmodule

// File: rtl/setpt_mode_fsm.sv
module setpt_mode_fsm #(
  parameter int unsigned DETECT_WIN = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic edge_evt,
  output logic pwm_mode,
  output logic analog_mode
);
  import setpt_pkg::*;

  localparam int unsigned WW = (DETECT_WIN > 1) ? $clog2(DETECT_WIN) : 1;

  mode_state_e      state;
  logic [WW-1:0]    win_cnt;
  logic             win_last;

  assign win_last = (win_cnt == WW'(DETECT_WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= MS_IDLE;
      win_cnt <= '0;
    end else if (ready) begin
      state   <= MS_WAIT;
      win_cnt <= '0;
    end else if (state == MS_WAIT) begin
      if (edge_evt)      state <= MS_PWM;
      else if (win_last) state <= MS_ANALOG;
      else               win_cnt <= win_cnt + 1'b1;
    end
  end

  assign pwm_mode    = (state == MS_PWM);
  assign analog_mode = (state == MS_ANALOG);

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_mode && analog_mode)); // R4
  AST_EDGE_PICKS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_WAIT && edge_evt && !ready) |=> pwm_mode); // R2
  AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_WAIT) |-> (32'(win_cnt) < DETECT_WIN)); // R3
  AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !ready) |=> pwm_mode); // R4
  AST_ANALOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (analog_mode && !ready) |=> analog_mode); // R4
endmodule

// File: rtl/setpt_duty_meter.sv
module setpt_duty_meter #(
  parameter int unsigned MAX_PERIOD = 781_250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       level,
  input  logic       rise,
  input  logic       fall,
  output logic [7:0] code,
  output logic       valid,
  output logic       shdn
);
  import setpt_pkg::*;

  localparam int unsigned CW = $clog2(MAX_PERIOD + 1);

  logic [CW-1:0] per_cnt, hi_cnt;
  logic          started, stalled;
  logic          tmo_evt, period_done;

  assign period_done = en && rise && started && !stalled;
  assign tmo_evt     = en && !rise && !stalled && (per_cnt >= CW'(MAX_PERIOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0; hi_cnt <= '0; started <= 1'b0; stalled <= 1'b0;
      code <= '0; valid <= 1'b0; shdn <= 1'b0;
    end else if (clr) begin
      per_cnt <= '0; hi_cnt <= '0; started <= 1'b0; stalled <= 1'b0;
      code <= '0; valid <= 1'b0; shdn <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (en) begin
        if (rise) begin
          if (period_done) begin
            code  <= duty_to_code(32'(hi_cnt), 32'(per_cnt));
            valid <= 1'b1;
            shdn  <= 1'b0;
          end
          started <= 1'b1;
          stalled <= 1'b0;
          per_cnt <= CW'(1);
          hi_cnt  <= CW'(1);
        end else if (stalled) begin
          if (fall) begin
            stalled <= 1'b0;
            per_cnt <= CW'(1);
            hi_cnt  <= '0;
          end
        end else if (tmo_evt) begin
          code    <= level ? 8'hFF : 8'h00;
          shdn    <= ~level;
          valid   <= 1'b1;
          stalled <= 1'b1;
          started <= 1'b0;
        end else begin
          per_cnt <= per_cnt + 1'b1;
          hi_cnt  <= hi_cnt + CW'(level);
        end
      end
    end
  end

  AST_VALID_IN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(en)); // R3
  AST_SHDN_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |-> (code == 8'h00)); // R7
  AST_HIGH_TMO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && level && !clr) |=> (code == 8'hFF && !shdn && valid)); // R8
  AST_HI_LE_PER: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= per_cnt); // R5
endmodule

// File: rtl/duty_setpoint_decoder.sv
module duty_setpoint_decoder #(
  parameter int unsigned DETECT_WIN = 2_000_000,
  parameter int unsigned MAX_PERIOD = 781_250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chg_ready,
  input  logic       pin_in,
  output logic       pwm_mode,
  output logic       analog_mode,
  output logic [7:0] sp_code,
  output logic       sp_valid,
  output logic       shdn_req
);
  logic pin_lvl, pin_rise, pin_fall, pin_edge;

  setpt_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign pin_edge = pin_rise | pin_fall;

  setpt_mode_fsm #(.DETECT_WIN(DETECT_WIN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ready(chg_ready), .edge_evt(pin_edge),
    .pwm_mode(pwm_mode), .analog_mode(analog_mode)
  );

  setpt_duty_meter #(.MAX_PERIOD(MAX_PERIOD)) u_meter (
    .clk(clk), .rst_n(rst_n), .clr(chg_ready), .en(pwm_mode),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall),
    .code(sp_code), .valid(sp_valid), .shdn(shdn_req)
  );

  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chg_ready |=> (!pwm_mode && !analog_mode && sp_code == 8'h00 && !shdn_req)); // R4
endmodule

// File: tb/duty_setpoint_decoder_tb.sv
module duty_setpoint_decoder_tb;
  localparam int unsigned WIN  = 300;
  localparam int unsigned MAXP = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chg_ready = 1'b0;
  logic pin_in = 1'b0;
  logic pwm_mode, analog_mode, sp_valid, shdn_req;
  logic [7:0] sp_code;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  duty_setpoint_decoder #(.DETECT_WIN(WIN), .MAX_PERIOD(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .chg_ready(chg_ready), .pin_in(pin_in),
    .pwm_mode(pwm_mode), .analog_mode(analog_mode), .sp_code(sp_code),
    .sp_valid(sp_valid), .shdn_req(shdn_req)
  );

  function automatic int ref_code(int h, int p);
    real r;
    int  v;
    r = (256.0 * h) / p;
    v = $rtoi(r + 0.5);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ready();
    @(negedge clk); chg_ready = 1'b1;
    @(negedge clk); chg_ready = 1'b0;
  endtask

  // Driver: one PWM period per loop, expected code queued for each period.
  task automatic pwm_periods(int h, int p, int n, string req);
    for (int i = 0; i < n; i++) begin
      pin_in = 1'b1; cyc(h);
      pin_in = 1'b0; cyc(p - h);
      exp_q.push_back(ref_code(h, p));
      tag_q.push_back(req);
    end
  endtask

  task automatic expect_item(int v, string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // Monitor: every strobe pops one expected code.
  always @(negedge clk) begin
    if (rst_n && sp_valid) begin
      if (exp_q.size() == 0) begin
        check("R3/R5 unexpected strobe", 1, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(sp_code), e);
      end
    end
  end

  initial begin
    cyc(400_000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(5);
    // R1 reset state
    check("R1 pwm_mode", pwm_mode, 0);
    check("R1 analog_mode", analog_mode, 0);
    check("R1 sp_code", sp_code, 0);
    check("R1 shdn_req", shdn_req, 0);
    rst_n = 1'b1;
    cyc(5);
    check("R1 idle after reset", pwm_mode | analog_mode, 0);

    // R3 analog decision, then toggles ignored
    pulse_ready();
    cyc(WIN + 10);
    check("R3 analog_mode", analog_mode, 1);
    check("R3 pwm_mode", pwm_mode, 0);
    for (int i = 0; i < 20; i++) begin
      pin_in = ~pin_in; cyc(7);
    end
    cyc(10);
    check("R3 code stays 0", sp_code, 0);
    check("R4 analog held", analog_mode, 1);

    // R2 falling-edge decision
    pin_in = 1'b1; cyc(10);
    pulse_ready();
    check("R4 ready clears analog", analog_mode, 0);
    cyc(50);
    pin_in = 1'b0;
    cyc(6);
    check("R2 pwm after falling edge", pwm_mode, 1);
    check("R4 exclusive", analog_mode, 0);
    cyc(10);

    // R5/R6/R9 duty measurement
    pwm_periods(64, 256, 3, "R5 25pct");
    pwm_periods(100, 300, 2, "R5 rounding");
    pwm_periods(199, 200, 2, "R6 99.5pct full scale");
    pwm_periods(500, MAXP, 1, "R9 longest period");
    pwm_periods(3, 8, 3, "R9 short period");
    pwm_periods(1, 200, 1, "R5 small duty");
    // R8 pin held high
    expect_item(255, "R8 high timeout");
    pin_in = 1'b1;
    cyc(MAXP + 100);
    check("R8 code full", sp_code, 255);
    check("R8 no shutdown", shdn_req, 0);

    // R7 pin held low: one strobe, shutdown
    expect_item(0, "R7 low timeout");
    pin_in = 1'b0;
    cyc(MAXP + 100);
    check("R7 shutdown set", shdn_req, 1);
    check("R7 code zero", sp_code, 0);
    cyc(MAXP + 100);
    check("R7 single strobe", exp_q.size(), 0);
    pwm_periods(128, 256, 2, "R5 resume after stall");
    pin_in = 1'b1; cyc(10);
    check("R7 shutdown cleared", shdn_req, 0);
    check("R5 queue drained", exp_q.size(), 0);

    // R4 ready restart, then R2 rising-edge decision
    pulse_ready();
    check("R4 ready clears pwm", pwm_mode, 0);
    check("R4 ready clears code", sp_code, 0);
    cyc(WIN + 10);
    check("R3 analog with pin high", analog_mode, 1);
    pin_in = 1'b0; cyc(10);
    pulse_ready();
    cyc(40);
    pin_in = 1'b1;
    cyc(6);
    check("R2 pwm after rising edge", pwm_mode, 1);
    cyc(10);
    check("R5 no result on first edge", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule